// File: doc/BRIEF.md
# I2C Filtered Bus Front-End

This block sits between the raw SCL and SDA pins and an I2C controller. Each line is cleaned by a majority-free hold filter: the cleaned level moves only when three consecutive samples on the system clock agree, and otherwise keeps its last value. From the two cleaned lines the block recognises START and STOP conditions. It then follows the byte and acknowledge phases of each transfer on rising edges of the cleaned SCL.

The first byte after every START is decoded as a 7-bit address and a direction bit. It is matched against a programmable own address and against the general call address. The block keeps a status vector with these flags: repeated START, lost arbitration, stored acknowledge, direction, addressed, general call and first byte. It also emits a one-cycle strobe with every received byte.

While the controller transmits, the block compares the level it releases on SDA with the cleaned SDA at each SCL rise. A mismatch latches a lost-arbitration flag, which stays set until software clears it.

The transfer tracker is a five-state machine:
- `PH_IDLE`: no transfer.
- `PH_ADDR`: shifting the address byte.
- `PH_ADDR_ACK`: acknowledge slot after the address.
- `PH_DATA`: shifting a data byte.
- `PH_DATA_ACK`: acknowledge slot after data.

Its transitions are:
- START takes any state to `PH_ADDR`.
- STOP takes any state to `PH_IDLE`.
- The eighth SCL rise in `PH_ADDR` goes to `PH_ADDR_ACK`.
- The eighth SCL rise in `PH_DATA` goes to `PH_DATA_ACK`.
- Any SCL rise in an acknowledge state goes to `PH_DATA`.

Top module: `i2c_bus_frontend`

## Requirements
- R1: After reset `scl_filt` and `sda_filt` are 1, `start_det`, `stop_det` and `byte_strobe` are 0, `rx_byte` is 0 and `status` is 7'b000_0100 (status bit 0 repeated START, 1 arbitration lost, 2 acknowledge bit, 3 direction, 4 addressed, 5 general call, 6 first byte).
- R2: A filtered output takes value v on the clock edge after its three most recent stored samples all equal v, and holds otherwise. A level held for three clocks therefore appears on the fourth rising edge, and a pulse of two clocks or less never appears.
- R3: `start_det` is a one-cycle pulse in the cycle after `sda_filt` falls while `scl_filt` stays 1. `stop_det` is the same for a rise of `sda_filt`.
- R4: Each rising edge of `scl_filt` in a byte phase samples `sda_filt`, most significant bit first. On the eighth such edge `byte_strobe` pulses for one cycle and `rx_byte` takes the assembled byte.
- R5: For the first byte after a START, `rx_byte[7:1]` is the address and `rx_byte[0]` is copied to status bit 3, where 1 means read.
- R6: Status bit 4 (addressed) is set at the end of the address byte when the address equals `own_addr` or seven zero bits. Status bit 5 (general call) is set when it equals seven zero bits.
- R7: Status bit 6 (first byte) is set with the address-byte strobe. It is cleared on the first SCL rise of the following data byte, or by a START or STOP.
- R8: A STOP clears status bits 0, 3, 4, 5 and 6 and returns the tracker to idle.
- R9: A START detected while a transfer is open (no STOP since the previous START) sets status bit 0. It stays set until a STOP.
- R10: The SCL rise that follows each byte (the ninth) copies `sda_filt` into status bit 2.
- R11: Status bit 1 is set after a rising `scl_filt` edge on which `tx_active` is 1, `sda_drive` is 1 and `sda_filt` is 0. With `tx_active` 0 the same bus activity leaves it unchanged.
- R12: Status bit 1 stays set until an `arb_clr` pulse clears it. A set condition in the same cycle as `arb_clr` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL level |
| sda_in | input | 1 | Raw SDA level |
| own_addr | input | 7 | Own slave address |
| tx_active | input | 1 | Controller is transmitting on SDA |
| sda_drive | input | 1 | Level the controller puts on SDA (1 = released) |
| arb_clr | input | 1 | One-cycle clear of the arbitration-lost flag |
| scl_filt | output | 1 | Filtered SCL |
| sda_filt | output | 1 | Filtered SDA |
| start_det | output | 1 | START pulse |
| stop_det | output | 1 | STOP pulse |
| byte_strobe | output | 1 | Byte received pulse |
| rx_byte | output | 8 | Last received byte |
| status | output | 7 | Status flags, bit map in R1 |

## Verification
The bench drives four kinds of traffic.
- An own-address write followed by a data byte checks the match, the direction and the first-byte clear.
- A repeated START to the general call address with a read bit separates the general-call flag from the own-address match and exercises the repeated-START flag.
- A non-matching address shows that the addressed flag stays low.
- Transmit bits with `tx_active` low and then high, both against a bus held low, show that only the transmitting case latches lost arbitration.

Two-clock SDA glitches during SCL high and a one-clock SCL glitch check that short pulses produce neither a false START, a false STOP nor an extra bit.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;
    localparam int LINES   = 2;
    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;

    localparam int STAT_W  = 7;
    localparam int ST_RS   = 0;
    localparam int ST_ARB  = 1;
    localparam int ST_ACK  = 2;
    localparam int ST_RD   = 3;
    localparam int ST_ADR  = 4;
    localparam int ST_GC   = 5;
    localparam int ST_FB   = 6;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_DATA,
        PH_DATA_ACK
    } phase_e;
endpackage

// File: rtl/i2cfe_line_filter.sv
module i2cfe_line_filter #(
    parameter int   DEPTH = 3,
    parameter logic INIT  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    logic [DEPTH-1:0] taps;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taps <= {DEPTH{INIT}};
            filt <= INIT;
        end else begin
            taps <= {taps[DEPTH-2:0], raw};
            if (&taps)
                filt <= 1'b1;
            else if (~|taps)
                filt <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cfe_cond_detect.sv
module i2cfe_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_p,
    output logic stop_p,
    output logic scl_rise
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign start_p  = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_p   = scl_f & scl_q & ~sda_q & sda_f;
    assign scl_rise = scl_f & ~scl_q;
endmodule

// File: rtl/i2cfe_xfer_fsm.sv
module i2cfe_xfer_fsm
    import i2cfe_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic              scl_rise,
    input  logic              sda_f,
    input  logic [BYTE_W-2:0] own_addr,
    output logic              byte_strobe,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rep_start,
    output logic              ack_bit,
    output logic              rd_dir,
    output logic              addressed,
    output logic              gen_call,
    output logic              first_byte
);
    localparam int ADDR_W = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    phase_e            state, state_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              last_bit;
    logic [BYTE_W-1:0] byte_nx;
    logic              gc_hit, own_hit;

    assign last_bit = (bit_cnt == LAST_BIT);
    assign byte_nx  = {shreg[BYTE_W-2:0], sda_f};
    assign gc_hit   = (shreg[ADDR_W-1:0] == '0);
    assign own_hit  = (shreg[ADDR_W-1:0] == own_addr);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= PH_IDLE;
        else
            state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            PH_IDLE:     state_nx = PH_IDLE;
            PH_ADDR:     if (scl_rise && last_bit) state_nx = PH_ADDR_ACK;
            PH_ADDR_ACK: if (scl_rise)             state_nx = PH_DATA;
            PH_DATA:     if (scl_rise && last_bit) state_nx = PH_DATA_ACK;
            PH_DATA_ACK: if (scl_rise)             state_nx = PH_DATA;
            default:     state_nx = PH_IDLE;
        endcase
        if (stop_p)
            state_nx = PH_IDLE;
        if (start_p)
            state_nx = PH_ADDR;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt     <= '0;
            shreg       <= '0;
            byte_strobe <= 1'b0;
            rx_byte     <= '0;
            rep_start   <= 1'b0;
            ack_bit     <= 1'b1;
            rd_dir      <= 1'b0;
            addressed   <= 1'b0;
            gen_call    <= 1'b0;
            first_byte  <= 1'b0;
        end else begin
            byte_strobe <= 1'b0;
            if (start_p) begin
                bit_cnt    <= '0;
                first_byte <= 1'b0;
                if (state != PH_IDLE)
                    rep_start <= 1'b1;
            end else if (stop_p) begin
                bit_cnt    <= '0;
                rep_start  <= 1'b0;
                rd_dir     <= 1'b0;
                addressed  <= 1'b0;
                gen_call   <= 1'b0;
                first_byte <= 1'b0;
            end else if (scl_rise) begin
                unique case (state)
                    PH_ADDR, PH_DATA: begin
                        shreg <= byte_nx;
                        if ((state == PH_DATA) && (bit_cnt == '0))
                            first_byte <= 1'b0;
                        if (last_bit) begin
                            bit_cnt     <= '0;
                            byte_strobe <= 1'b1;
                            rx_byte     <= byte_nx;
                            if (state == PH_ADDR) begin
                                rd_dir     <= sda_f;
                                gen_call   <= gc_hit;
                                addressed  <= gc_hit | own_hit;
                                first_byte <= 1'b1;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    PH_ADDR_ACK, PH_DATA_ACK: ack_bit <= sda_f;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cfe_arb_mon.sv
module i2cfe_arb_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_rise,
    input  logic sda_f,
    input  logic tx_active,
    input  logic sda_drive,
    input  logic arb_clr,
    output logic arb_lost
);
    logic clash;

    assign clash = tx_active & sda_drive & ~sda_f & scl_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            arb_lost <= 1'b0;
        else if (clash)
            arb_lost <= 1'b1;
        else if (arb_clr)
            arb_lost <= 1'b0;
    end
endmodule

// File: rtl/i2c_bus_frontend.sv
module i2c_bus_frontend
    import i2cfe_pkg::*;
#(
    parameter int FILT_DEPTH = 3,
    parameter int BYTE_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [BYTE_W-2:0] own_addr,
    input  logic              tx_active,
    input  logic              sda_drive,
    input  logic              arb_clr,
    output logic              scl_filt,
    output logic              sda_filt,
    output logic              start_det,
    output logic              stop_det,
    output logic              byte_strobe,
    output logic [BYTE_W-1:0] rx_byte,
    output logic [STAT_W-1:0] status
);
    logic [LINES-1:0] raw_lines, filt_lines;
    logic scl_rise;
    logic rep_start, ack_bit, rd_dir, addressed, gen_call, first_byte, arb_lost;

    assign raw_lines[LINE_SCL] = scl_in;
    assign raw_lines[LINE_SDA] = sda_in;

    for (genvar g = 0; g < LINES; g++) begin : g_filt
        i2cfe_line_filter #(.DEPTH(FILT_DEPTH), .INIT(1'b1)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_lines[g]),
            .filt (filt_lines[g])
        );
    end

    assign scl_filt = filt_lines[LINE_SCL];
    assign sda_filt = filt_lines[LINE_SDA];

    i2cfe_cond_detect u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_filt),
        .sda_f   (sda_filt),
        .start_p (start_det),
        .stop_p  (stop_det),
        .scl_rise(scl_rise)
    );

    i2cfe_xfer_fsm #(.BYTE_W(BYTE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_p    (start_det),
        .stop_p     (stop_det),
        .scl_rise   (scl_rise),
        .sda_f      (sda_filt),
        .own_addr   (own_addr),
        .byte_strobe(byte_strobe),
        .rx_byte    (rx_byte),
        .rep_start  (rep_start),
        .ack_bit    (ack_bit),
        .rd_dir     (rd_dir),
        .addressed  (addressed),
        .gen_call   (gen_call),
        .first_byte (first_byte)
    );

    i2cfe_arb_mon u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .sda_f    (sda_filt),
        .tx_active(tx_active),
        .sda_drive(sda_drive),
        .arb_clr  (arb_clr),
        .arb_lost (arb_lost)
    );

    always_comb begin
        status         = '0;
        status[ST_RS]  = rep_start;
        status[ST_ARB] = arb_lost;
        status[ST_ACK] = ack_bit;
        status[ST_RD]  = rd_dir;
        status[ST_ADR] = addressed;
        status[ST_GC]  = gen_call;
        status[ST_FB]  = first_byte;
    end
endmodule

// File: rtl/i2cfe_chk.sv
module i2cfe_chk
    import i2cfe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_in,
    input logic              scl_filt,
    input logic              sda_filt,
    input logic              start_det,
    input logic              stop_det,
    input logic              byte_strobe,
    input logic              tx_active,
    input logic              sda_drive,
    input logic              arb_clr,
    input logic [STAT_W-1:0] status
);
    logic [2:0] warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            warm <= '0;
        else if (warm != 3'd7)
            warm <= warm + 3'd1;
    end

    // R2
    filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 3'd5 && scl_filt != $past(scl_filt)) |->
        ($past(scl_in, 2) == scl_filt && $past(scl_in, 3) == scl_filt && $past(scl_in, 4) == scl_filt));

    // R3
    start_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |-> scl_filt);

    // R4
    strobe_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_strobe |-> scl_filt);

    // R6
    gc_implies_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_GC] |-> status[ST_ADR]);

    // R8
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!status[ST_ADR] && !status[ST_FB] && !status[ST_RS]));

    // R11
    arb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 3'd2 && tx_active && sda_drive && !sda_filt && scl_filt && !$past(scl_filt))
        |=> status[ST_ARB]);

    // R12
    arb_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_ARB] && !arb_clr) |=> status[ST_ARB]);
endmodule

bind i2c_bus_frontend i2cfe_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_in),
    .scl_filt   (scl_filt),
    .sda_filt   (sda_filt),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .byte_strobe(byte_strobe),
    .tx_active  (tx_active),
    .sda_drive  (sda_drive),
    .arb_clr    (arb_clr),
    .status     (status)
);

// File: tb/sim_i2c_bus_frontend.sv
`timescale 1ns/1ps
module sim_i2c_bus_frontend;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_in = 1'b1, sda_in = 1'b1;
    logic [6:0] own_addr = 7'h2A;
    logic       tx_active = 1'b0, sda_drive = 1'b1, arb_clr = 1'b0;
    logic       scl_filt, sda_filt, start_det, stop_det, byte_strobe;
    logic [7:0] rx_byte;
    logic [6:0] status;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2c_bus_frontend u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .own_addr(own_addr), .tx_active(tx_active), .sda_drive(sda_drive),
        .arb_clr(arb_clr), .scl_filt(scl_filt), .sda_filt(sda_filt),
        .start_det(start_det), .stop_det(stop_det), .byte_strobe(byte_strobe),
        .rx_byte(rx_byte), .status(status)
    );

    task automatic cmp(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int q_scl[$], q_sda[$];
    bit m_sclf, m_sdaf, m_sclq, m_sdaq;
    int m_phase;          // 0 idle, 1 address bits, 2 address ack, 3 data bits, 4 data ack
    int m_nbits, m_acc, m_rx;
    bit m_strobe, m_rs, m_arb, m_ack, m_rd, m_adr, m_gc, m_fb;

    function automatic bit all_eq(ref int q[$], input int v);
        foreach (q[i]) if (q[i] != v) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q_scl = '{1, 1, 1}; q_sda = '{1, 1, 1};
            m_sclf = 1; m_sdaf = 1; m_sclq = 1; m_sdaq = 1;
            m_phase = 0; m_nbits = 0; m_acc = 0; m_rx = 0;
            m_strobe = 0; m_rs = 0; m_arb = 0; m_ack = 1;
            m_rd = 0; m_adr = 0; m_gc = 0; m_fb = 0;
        end else begin
            bit st, sp, rise;
            st   = m_sclf && m_sclq && m_sdaq && !m_sdaf;
            sp   = m_sclf && m_sclq && !m_sdaq && m_sdaf;
            rise = m_sclf && !m_sclq;
            m_strobe = 0;
            if (tx_active && sda_drive && !m_sdaf && rise) m_arb = 1;
            else if (arb_clr) m_arb = 0;
            if (st) begin
                if (m_phase != 0) m_rs = 1;
                m_phase = 1; m_nbits = 0; m_fb = 0;
            end else if (sp) begin
                m_phase = 0; m_nbits = 0; m_rs = 0; m_rd = 0;
                m_adr = 0; m_gc = 0; m_fb = 0;
            end else if (rise) begin
                if (m_phase == 1 || m_phase == 3) begin
                    if (m_phase == 3 && m_nbits == 0) m_fb = 0;
                    m_acc = ((m_acc << 1) | int'(m_sdaf)) & 255;
                    m_nbits++;
                    if (m_nbits == 8) begin
                        m_nbits = 0; m_strobe = 1; m_rx = m_acc;
                        if (m_phase == 1) begin
                            m_rd  = m_acc[0];
                            m_gc  = (m_acc >> 1) == 0;
                            m_adr = m_gc || ((m_acc >> 1) == int'(own_addr));
                            m_fb  = 1;
                            m_phase = 2;
                        end else m_phase = 4;
                    end
                end else if (m_phase == 2 || m_phase == 4) begin
                    m_ack = m_sdaf;
                    m_phase = 3;
                end
            end
            m_sclq = m_sclf; m_sdaq = m_sdaf;
            if (all_eq(q_scl, 1)) m_sclf = 1; else if (all_eq(q_scl, 0)) m_sclf = 0;
            if (all_eq(q_sda, 1)) m_sdaf = 1; else if (all_eq(q_sda, 0)) m_sdaf = 0;
            q_scl.push_back(int'(scl_in)); void'(q_scl.pop_front());
            q_sda.push_back(int'(sda_in)); void'(q_sda.pop_front());
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp("R2",  "scl_filt", scl_filt, m_sclf);
            cmp("R2",  "sda_filt", sda_filt, m_sdaf);
            cmp("R3",  "start_det", start_det, m_sclf && m_sclq && m_sdaq && !m_sdaf);
            cmp("R3",  "stop_det",  stop_det,  m_sclf && m_sclq && !m_sdaq && m_sdaf);
            cmp("R4",  "byte_strobe", byte_strobe, m_strobe);
            cmp("R4",  "rx_byte", rx_byte, m_rx);
            cmp("R5",  "dir", status[3], m_rd);
            cmp("R6",  "addressed", status[4], m_adr);
            cmp("R6",  "gen_call", status[5], m_gc);
            cmp("R7",  "first_byte", status[6], m_fb);
            cmp("R9",  "rep_start", status[0], m_rs);
            cmp("R10", "ack", status[2], m_ack);
            cmp("R11", "arb_lost", status[1], m_arb);
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        scl_in = 1; sda_in = 1; tick(H);
        sda_in = 0; tick(H);
        scl_in = 0; tick(H);
    endtask

    task automatic bus_rstart();
        sda_in = 1; tick(H);
        scl_in = 1; tick(H);
        sda_in = 0; tick(H);
        scl_in = 0; tick(H);
    endtask

    task automatic bus_stop();
        sda_in = 0; tick(H);
        scl_in = 1; tick(H);
        sda_in = 1; tick(H);
    endtask

    task automatic bus_bit(bit b, bit glitch);
        sda_in = b; tick(H);
        scl_in = 1; tick(3);
        if (glitch) begin sda_in = ~b; tick(2); sda_in = b; end
        else tick(2);
        tick(3);
        scl_in = 0; tick(H);
    endtask

    task automatic bus_byte(logic [7:0] v, bit glitch);
        for (int i = 7; i >= 0; i--) bus_bit(v[i], glitch && (i == 4));
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        // R1 reset state
        cmp("R1", "scl_filt", scl_filt, 1);
        cmp("R1", "sda_filt", sda_filt, 1);
        cmp("R1", "strobe", byte_strobe, 0);
        cmp("R1", "rx_byte", rx_byte, 0);
        cmp("R1", "status", status, 7'b000_0100);
        tick(4);

        // own-address write, acked
        bus_start();
        bus_byte({7'h2A, 1'b0}, 1'b0);
        cmp("R6", "own match", status[4], 1);
        cmp("R5", "write dir", status[3], 0);
        cmp("R7", "first byte set", status[6], 1);
        cmp("R4", "addr byte", rx_byte, 8'h54);
        bus_bit(0, 0);
        cmp("R10", "ack low", status[2], 0);

        // data byte with SDA glitch during SCL high, then nack
        bus_byte(8'hC3, 1'b1);
        cmp("R4", "data byte", rx_byte, 8'hC3);
        cmp("R7", "first byte cleared", status[6], 0);
        cmp("R2", "glitch no stop", status[4], 1);
        bus_bit(1, 0);
        cmp("R10", "nack", status[2], 1);

        // one-clock SCL glitch in low phase: no extra bit
        scl_in = 1; tick(1); scl_in = 0; tick(H);

        // repeated START to general call, read
        bus_rstart();
        cmp("R9", "rep start", status[0], 1);
        bus_byte({7'h00, 1'b1}, 1'b0);
        cmp("R6", "gen call", status[5], 1);
        cmp("R6", "gc addressed", status[4], 1);
        cmp("R5", "read dir", status[3], 1);
        bus_bit(0, 0);

        // STOP clears
        bus_stop();
        tick(6);
        cmp("R8", "addressed cleared", status[4], 0);
        cmp("R8", "first cleared", status[6], 0);
        cmp("R8", "rep cleared", status[0], 0);
        cmp("R8", "gc cleared", status[5], 0);

        // non-matching address
        bus_start();
        cmp("R9", "fresh start no rep", status[0], 0);
        bus_byte({7'h15, 1'b0}, 1'b0);
        cmp("R6", "no match", status[4], 0);
        bus_bit(1, 0);

        // arbitration: not transmitting, bus low -> no effect
        sda_drive = 1; tx_active = 0;
        bus_bit(0, 0);
        cmp("R11", "no tx no arb", status[1], 0);
        // transmitting released-high, bus low -> lost
        tx_active = 1;
        bus_bit(0, 0);
        tx_active = 0;
        cmp("R11", "arb set", status[1], 1);
        tick(20);
        cmp("R12", "arb sticky", status[1], 1);
        arb_clr = 1; tick(1); arb_clr = 0; tick(1);
        cmp("R12", "arb cleared", status[1], 0);
        // transmitting and bus matches -> no set
        tx_active = 1;
        bus_bit(1, 0);
        tx_active = 0;
        cmp("R11", "match no arb", status[1], 0);

        bus_stop();
        tick(10);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule